// File: doc/BRIEF.md
# Transmit Statistics Counter Bank

This block keeps the transmit-side statistics of an Ethernet MAC that runs in half or full duplex. The transmit engine reports each finished frame with a single-cycle completion strobe. The strobe carries the frame length and a set of outcome flags. The flags give the address class (broadcast or multicast), whether the frame was a pause frame or another control frame, the number of collisions seen, late-collision and excessive-collision aborts, ordinary and excessive deferral, data underrun, length-field mismatch and oversize truncation.

The block sorts every report into a bank of saturating counters. A frame that ends in a late collision, an excessive-collision abort or an underrun is an aborted frame. Only frames that are not aborted reach the good-frame counters, the byte totals and the frame-size histogram. Software reads the bank through a simple indexed read port. Every read returns the counter's value one cycle later and clears that counter at the same time.

Top module: `tx_stat_bank`

## Requirements
- R1: A report with none of the late-collision, excessive-collision or underrun flags is a good frame and increments counter 0. An aborted report changes no counter at index 0 to 4, 7, 8 or 14 to 23.
- R2: A good frame with collision count exactly 1 increments counter 7. A good frame with collision count 2 or more increments counter 8. A collision count of 0 touches neither.
- R3: Every report with the late-collision flag increments counter 9. Every report with the excessive-collision flag increments counter 10.
- R4: The ordinary-deferral flag increments counter 5 and the excessive-deferral flag increments counter 6. The two are independent, and both count whether or not the frame was aborted.
- R5: Every report with the underrun flag increments counter 11.
- R6: A good frame increments exactly one size bin, chosen by its length including FCS. The bins are counters 17 to 23: length up to 64, 65 to 127, 128 to 255, 256 to 511, 512 to 1023, 1024 to 1518, and 1519 or more.
- R7: For a good frame, counter 14 adds the length minus 4 (FCS excluded). Counter 15 adds the same amount only for broadcast frames, and counter 16 only for multicast frames.
- R8: The length-mismatch flag increments counter 12 and the truncation flag increments counter 13, whether or not the frame was aborted.
- R9: When the read enable is high, the read data output in the next cycle holds the value of the counter at the read index, and that counter is cleared.
- R10: A read that falls in the same cycle as an increment of the same counter returns the old value and leaves the counter holding the new increment.
- R11: Counters saturate at all-ones and never wrap.
- R12: After reset every counter reads zero.
- R13: Good broadcast, multicast, pause and control frames increment counters 1, 2, 3 and 4 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | Frame completion strobe |
| ev_len_i | input | LEN_W | Frame length including FCS |
| ev_bcast_i | input | 1 | Broadcast destination |
| ev_mcast_i | input | 1 | Multicast destination |
| ev_pause_i | input | 1 | Pause frame |
| ev_ctrl_i | input | 1 | Control frame other than pause |
| ev_col_cnt_i | input | COL_W | Collisions seen before completion |
| ev_late_col_i | input | 1 | Aborted by late collision |
| ev_exc_col_i | input | 1 | Aborted by excessive collisions |
| ev_defer_i | input | 1 | Frame was deferred |
| ev_exc_defer_i | input | 1 | Frame was excessively deferred |
| ev_underrun_i | input | 1 | Aborted by data or descriptor underrun |
| ev_len_err_i | input | 1 | Length field does not match size |
| ev_trunc_i | input | 1 | Truncated for exceeding the MTU |
| rd_en_i | input | 1 | Read and clear strobe |
| rd_addr_i | input | ADDR_W | Counter index |
| rd_data_o | output | CNT_W | Counter value, one cycle after the read |

## Verification
Each counter is its own register and is visible only through a read. A wrong increment, a missing clear or a wrap therefore shows up as a wrong value on the next read of that index, one cycle after the read strobe. Every scenario ends with a read of the whole bank. This catches stray increments in unrelated counters, such as an aborted frame leaking into a size bin or a byte total. It also confirms that each counter is back at zero before the next scenario starts.

// File: rtl/tx_stat_pkg.sv
package tx_stat_pkg;
  localparam int IDX_OK        = 0;
  localparam int IDX_BCAST     = 1;
  localparam int IDX_MCAST     = 2;
  localparam int IDX_PAUSE     = 3;
  localparam int IDX_CTRL      = 4;
  localparam int IDX_DEFER     = 5;
  localparam int IDX_XDEFER    = 6;
  localparam int IDX_COL1      = 7;
  localparam int IDX_COLN      = 8;
  localparam int IDX_LATE      = 9;
  localparam int IDX_XCOL      = 10;
  localparam int IDX_UNDERRUN  = 11;
  localparam int IDX_LEN_ERR   = 12;
  localparam int IDX_TRUNC     = 13;
  localparam int IDX_BYTES     = 14;
  localparam int IDX_BC_BYTES  = 15;
  localparam int IDX_MC_BYTES  = 16;
  localparam int IDX_BIN0      = 17;
  localparam int NUM_BINS      = 7;
  localparam int NUM_CNT       = IDX_BIN0 + NUM_BINS;
  localparam int FCS_LEN       = 4;

  // inclusive upper edge of bin b; last bin is open
  function automatic int unsigned bin_top(int unsigned b);
    if (b == 0) return 64;
    if (b < 5) return (64 << b) - 1;
    return 1518;
  endfunction
endpackage

// File: rtl/tx_stat_classify.sv
module tx_stat_classify
  import tx_stat_pkg::*;
#(
  parameter int LEN_W = 14,
  parameter int COL_W = 4
) (
  input  logic                            valid_i,
  input  logic [LEN_W-1:0]                len_i,
  input  logic                            bcast_i,
  input  logic                            mcast_i,
  input  logic                            pause_i,
  input  logic                            ctrl_i,
  input  logic [COL_W-1:0]                col_cnt_i,
  input  logic                            late_col_i,
  input  logic                            exc_col_i,
  input  logic                            defer_i,
  input  logic                            exc_defer_i,
  input  logic                            underrun_i,
  input  logic                            len_err_i,
  input  logic                            trunc_i,
  output logic [NUM_CNT-1:0][LEN_W-1:0]   inc_o
);
  logic             good;
  logic [LEN_W-1:0] bytes;

  assign good  = valid_i && !(late_col_i || exc_col_i || underrun_i);
  assign bytes = (len_i >= LEN_W'(FCS_LEN)) ? len_i - LEN_W'(FCS_LEN) : '0;

  always_comb begin
    inc_o = '0;
    if (valid_i) begin
      inc_o[IDX_DEFER]    = LEN_W'(defer_i);
      inc_o[IDX_XDEFER]   = LEN_W'(exc_defer_i);
      inc_o[IDX_LATE]     = LEN_W'(late_col_i);
      inc_o[IDX_XCOL]     = LEN_W'(exc_col_i);
      inc_o[IDX_UNDERRUN] = LEN_W'(underrun_i);
      inc_o[IDX_LEN_ERR]  = LEN_W'(len_err_i);
      inc_o[IDX_TRUNC]    = LEN_W'(trunc_i);
    end
    if (good) begin
      inc_o[IDX_OK]       = LEN_W'(1);
      inc_o[IDX_BCAST]    = LEN_W'(bcast_i);
      inc_o[IDX_MCAST]    = LEN_W'(mcast_i);
      inc_o[IDX_PAUSE]    = LEN_W'(pause_i);
      inc_o[IDX_CTRL]     = LEN_W'(ctrl_i);
      inc_o[IDX_COL1]     = LEN_W'(col_cnt_i == COL_W'(1));
      inc_o[IDX_COLN]     = LEN_W'(col_cnt_i > COL_W'(1));
      inc_o[IDX_BYTES]    = bytes;
      inc_o[IDX_BC_BYTES] = bcast_i ? bytes : '0;
      inc_o[IDX_MC_BYTES] = mcast_i ? bytes : '0;
      for (int b = 0; b < NUM_BINS; b++) begin
        inc_o[IDX_BIN0+b] = LEN_W'(
          (b == 0 || 32'(len_i) > bin_top(32'(b - 1))) &&
          (b == NUM_BINS - 1 || 32'(len_i) <= bin_top(32'(b))));
      end
    end
  end
endmodule

// File: rtl/tx_stat_ctr.sv
module tx_stat_ctr #(
  parameter int CNT_W = 32,
  parameter int INC_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;
  localparam logic [SUM_W-1:0] MAX = SUM_W'({CNT_W{1'b1}});

  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum;

  assign sum = (clr_i ? '0 : SUM_W'(cnt_q)) + SUM_W'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (sum > MAX)  cnt_q <= '1;
    else                 cnt_q <= sum[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;

  // R11
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_q >= $past(cnt_q));

  // R9
  clr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && inc_i == '0) |=> cnt_q == '0);
endmodule

// File: rtl/tx_stat_bank.sv
module tx_stat_bank
  import tx_stat_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 14,
  parameter int COL_W  = 4,
  parameter int ADDR_W = $clog2(NUM_CNT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  input  logic [LEN_W-1:0]  ev_len_i,
  input  logic              ev_bcast_i,
  input  logic              ev_mcast_i,
  input  logic              ev_pause_i,
  input  logic              ev_ctrl_i,
  input  logic [COL_W-1:0]  ev_col_cnt_i,
  input  logic              ev_late_col_i,
  input  logic              ev_exc_col_i,
  input  logic              ev_defer_i,
  input  logic              ev_exc_defer_i,
  input  logic              ev_underrun_i,
  input  logic              ev_len_err_i,
  input  logic              ev_trunc_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o
);
  logic [NUM_CNT-1:0][LEN_W-1:0] inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [NUM_BINS-1:0]           bin_hit;
  logic [CNT_W-1:0]              rd_data_q;

  tx_stat_classify #(.LEN_W(LEN_W), .COL_W(COL_W)) u_cls (
    .valid_i    (ev_valid_i),
    .len_i      (ev_len_i),
    .bcast_i    (ev_bcast_i),
    .mcast_i    (ev_mcast_i),
    .pause_i    (ev_pause_i),
    .ctrl_i     (ev_ctrl_i),
    .col_cnt_i  (ev_col_cnt_i),
    .late_col_i (ev_late_col_i),
    .exc_col_i  (ev_exc_col_i),
    .defer_i    (ev_defer_i),
    .exc_defer_i(ev_exc_defer_i),
    .underrun_i (ev_underrun_i),
    .len_err_i  (ev_len_err_i),
    .trunc_i    (ev_trunc_i),
    .inc_o      (inc)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    tx_stat_ctr #(.CNT_W(CNT_W), .INC_W(LEN_W)) u_ctr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (inc[i]),
      .clr_i (rd_en_i && (32'(rd_addr_i) == i)),
      .cnt_o (cnt[i])
    );
  end

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    assign bin_hit[b] = inc[IDX_BIN0+b] != '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_q <= '0;
    else if (rd_en_i)
      rd_data_q <= (32'(rd_addr_i) < NUM_CNT) ? cnt[rd_addr_i] : '0;
  end

  assign rd_data_o = rd_data_q;

  // R9
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  // R6
  one_bin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bin_hit));

  // R1
  abort_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && (ev_late_col_i || ev_exc_col_i || ev_underrun_i))
      |-> (inc[IDX_OK] == '0 && bin_hit == '0 && inc[IDX_BYTES] == '0));

  // R2
  col_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc[IDX_COL1] != '0 && inc[IDX_COLN] != '0));
endmodule

// File: tb/tx_stat_bank_test.sv
module tx_stat_bank_test;
  localparam int CNT_W = 12;
  localparam int LEN_W = 14;
  localparam int COL_W = 4;
  localparam int NCNT  = 24;
  localparam int AW    = 5;

  localparam int F_BC = 0, F_MC = 1, F_PAUSE = 2, F_CTRL = 3, F_LATE = 4,
                 F_XCOL = 5, F_DEF = 6, F_XDEF = 7, F_UND = 8, F_LERR = 9,
                 F_TRUNC = 10;

  logic clk = 0, rst_n = 0;
  logic ev_valid = 0;
  logic [LEN_W-1:0] ev_len = '0;
  logic [COL_W-1:0] ev_col = '0;
  logic [10:0] fl = '0;
  logic rd_en = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [CNT_W-1:0] rd_data;

  int checks = 0, failures = 0;
  int exp_v [NCNT];

  always #5 clk = ~clk;

  tx_stat_bank #(.CNT_W(CNT_W), .LEN_W(LEN_W), .COL_W(COL_W), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ev_valid_i(ev_valid), .ev_len_i(ev_len),
    .ev_bcast_i(fl[F_BC]), .ev_mcast_i(fl[F_MC]),
    .ev_pause_i(fl[F_PAUSE]), .ev_ctrl_i(fl[F_CTRL]),
    .ev_col_cnt_i(ev_col), .ev_late_col_i(fl[F_LATE]),
    .ev_exc_col_i(fl[F_XCOL]), .ev_defer_i(fl[F_DEF]),
    .ev_exc_defer_i(fl[F_XDEF]), .ev_underrun_i(fl[F_UND]),
    .ev_len_err_i(fl[F_LERR]), .ev_trunc_i(fl[F_TRUNC]),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  function automatic string tag_of(int i);
    if (i == 0) return "R1";
    if (i <= 4) return "R13";
    if (i <= 6) return "R4";
    if (i <= 8) return "R2";
    if (i <= 10) return "R3";
    if (i == 11) return "R5";
    if (i <= 13) return "R8";
    if (i <= 16) return "R7";
    return "R6";
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic send(int len, int col, logic [10:0] f);
    @(negedge clk);
    ev_valid = 1; ev_len = LEN_W'(len); ev_col = COL_W'(col); fl = f;
    @(negedge clk);
    ev_valid = 0; fl = '0; ev_col = '0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    rd_en = 1; rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 0;
    d = int'(rd_data);
  endtask

  task automatic clear_exp();
    for (int i = 0; i < NCNT; i++) exp_v[i] = 0;
  endtask

  task automatic chk_all(string ovr);
    int d;
    for (int i = 0; i < NCNT; i++) begin
      rd(i, d);
      check(ovr != "" ? ovr : tag_of(i), d, exp_v[i], $sformatf("counter %0d", i));
    end
    clear_exp();
  endtask

  // R12
  task automatic t_reset();
    clear_exp();
    chk_all("R12");
  endtask

  // R1 R13 R6 R7
  task automatic t_good();
    send(64, 0, 11'(1 << F_BC));
    send(127, 0, 11'(1 << F_MC));
    send(128, 0, 11'(1 << F_PAUSE));
    send(1518, 0, 11'(1 << F_CTRL));
    send(1519, 0, '0);
    send(65, 0, '0);
    exp_v[0] = 6; exp_v[1] = 1; exp_v[2] = 1; exp_v[3] = 1; exp_v[4] = 1;
    exp_v[14] = 60 + 123 + 124 + 1514 + 1515 + 61;
    exp_v[15] = 60; exp_v[16] = 123;
    exp_v[17] = 1; exp_v[18] = 2; exp_v[19] = 1; exp_v[22] = 1; exp_v[23] = 1;
    chk_all("");
  endtask

  // R2 R3 R1
  task automatic t_col();
    send(64, 1, '0);
    send(64, 3, '0);
    send(200, 2, 11'((1 << F_LATE) | (1 << F_BC)));
    send(300, 15, 11'((1 << F_XCOL) | (1 << F_MC)));
    send(64, 0, '0);
    exp_v[0] = 3; exp_v[7] = 1; exp_v[8] = 1; exp_v[9] = 1; exp_v[10] = 1;
    exp_v[14] = 180; exp_v[17] = 3;
    chk_all("");
  endtask

  // R4 R5 R8
  task automatic t_defer();
    send(64, 0, 11'(1 << F_DEF));
    send(64, 0, 11'((1 << F_DEF) | (1 << F_XDEF)));
    send(300, 0, 11'((1 << F_UND) | (1 << F_DEF)));
    send(2000, 0, 11'(1 << F_TRUNC));
    send(80, 0, 11'((1 << F_LERR) | (1 << F_UND)));
    exp_v[0] = 3; exp_v[5] = 3; exp_v[6] = 1; exp_v[11] = 2;
    exp_v[12] = 1; exp_v[13] = 1;
    exp_v[14] = 60 + 60 + 1996; exp_v[17] = 2; exp_v[23] = 1;
    chk_all("");
  endtask

  // R11
  task automatic t_sat();
    int d;
    for (int k = 0; k < 3; k++) send(1518, 0, 11'(1 << F_BC));
    rd(14, d); check("R11", d, 4095, "byte total saturation");
    rd(15, d); check("R11", d, 4095, "bcast byte saturation");
    exp_v[0] = 3; exp_v[1] = 3; exp_v[22] = 3;
    chk_all("");
  endtask

  // R10
  task automatic t_coincide();
    int d;
    send(64, 0, '0);
    @(negedge clk);
    rd_en = 1; rd_addr = AW'(0);
    ev_valid = 1; ev_len = LEN_W'(64); fl = '0;
    @(negedge clk);
    rd_en = 0; ev_valid = 0;
    check("R10", int'(rd_data), 1, "value read during increment");
    exp_v[0] = 1; exp_v[14] = 120; exp_v[17] = 2;
    chk_all("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_good();
    t_col();
    t_defer();
    t_sat();
    t_coincide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule